// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block sits on the controller side of a four-bank double data rate SDRAM. After reset it holds the clock enable low through a long power-up wait. It then runs the start-up sequence: precharge of every bank, the extended and base mode register writes, and two auto refreshes. Only after that does it accept host traffic. From then on it turns each single read or write request into an ACTIVE, a READ or WRITE and, unless auto precharge was asked for, a PRECHARGE to the same bank. It keeps the row-to-column and precharge spacing while doing so.

A free-running interval timer raises a refresh demand at a fixed period. That demand is served as soon as the access in flight has finished, ahead of any new host request. It is served by a precharge of all banks followed by AUTO REFRESH. For reads the sequencer also produces a data-valid window that follows the programmed CAS latency and burst length. A flag marks the half-cycle CAS latency, whose beats arrive on the falling clock edge.

Top module: `sdr_cmd_seq`

## Requirements
- R1: While reset is held, and for INIT_CYCLES cycles after its release, CKE is low and the bus carries NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1). The first non-NOP command comes no earlier than INIT_CYCLES cycles after release.
- R2: The start-up order is fixed. First comes PRECHARGE with address bit 10 set. Then comes MODE SET (cs_n=0, ras_n=0, cas_n=0, we_n=0) with bank 1 and address 0. Then MODE SET with bank 0. Then two AUTO REFRESH (0,0,0,1). Host ready stays low and no ACTIVE is issued before the second of these refreshes.
- R3: The bank-0 mode word sets address bits [2:0] to 001, 010 or 011 for bursts of 2, 4 or 8 (cfg_bl = 0, 1, 2). Bit 3 is 0. Bits [6:4] are 010 for CAS latency 2 and 110 for 2.5. All other bits are 0.
- R4: ACTIVE (0,0,1,1) carries the request's bank and row. READ (0,1,0,1) or WRITE (0,1,0,0) carries the same bank, the column on address bits [9:0] and the auto-precharge flag on bit 10.
- R5: READ or WRITE follows its ACTIVE by exactly TRCD = 3 cycles.
- R6: Without auto precharge, PRECHARGE (0,0,1,0) with bit 10 clear goes to the same bank exactly BL/2 cycles after a READ, or BL/2+TWR cycles after a WRITE. The next ACTIVE to that bank comes at least TRP = 3 cycles after the PRECHARGE.
- R7: With auto precharge, no PRECHARGE is issued for that access. The next ACTIVE to that bank waits at least BL/2 (+TWR for a write) +TRP cycles after the READ or WRITE.
- R8: After a READ at cycle k, rd_valid is high for exactly BL/2 consecutive cycles starting at cycle k+2 (CAS latency 2) or k+3 (CAS latency 2.5). rd_late is high in exactly those cycles when the latency is 2.5, and never otherwise.
- R9: A request is taken only in a cycle where req_valid and req_ready are both high, and every accepted request is carried out in order. req_done is high for one cycle, exactly when that request's READ or WRITE is on the bus, and at no other time.
- R10: Every AUTO REFRESH comes at least TRP cycles after a PRECHARGE with bit 10 set, with no bank left open. During normal operation, consecutive refreshes are never more than REFI_CYCLES+20 cycles apart, even under back-to-back host traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, commands on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cl_half | input | 1 | 1 selects CAS latency 2.5, 0 selects 2 |
| cfg_bl | input | 2 | Burst length code: 0 = 2, 1 = 4, 2 = 8 |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ap | input | 1 | Close the row automatically after the burst |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Target column |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| req_done | output | 1 | Pulses with the request's READ/WRITE command |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Row / column / mode address |
| rd_valid | output | 1 | Read data window, one cycle per two beats |
| rd_late | output | 1 | Window beats land on the falling edge (latency 2.5) |

## Verification
The bench keeps its own log of every command per bank. It goes after the spacing corners: READ/WRITE one cycle early after ACTIVE, a missing write recovery before PRECHARGE, an ACTIVE that follows an auto-precharged burst too soon, and a refresh that is starved by a stream of host requests. A design that mishandled these would show an off-by-one gap, an open bank at PRECHARGE-all, or a refresh gap beyond the interval bound. It also checks the mode word and the read window under every burst code and both latencies. A wrong latency count or beat count would shift or stretch rd_valid. Boundary rows and columns (all ones) check that the auto-precharge bit never mixes into the column.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    localparam int BA_W  = 2;
    localparam int ROW_W = 13;
    localparam int COL_W = 10;
    localparam int AP_POS = 10;
    localparam logic [ROW_W-1:0] AP_MASK = ROW_W'(1) << AP_POS;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP = '{1'b0, 1'b1, 1'b1, 1'b1};
    localparam sd_cmd_t CMD_ACT = '{1'b0, 1'b0, 1'b1, 1'b1};
    localparam sd_cmd_t CMD_RD  = '{1'b0, 1'b1, 1'b0, 1'b1};
    localparam sd_cmd_t CMD_WR  = '{1'b0, 1'b1, 1'b0, 1'b0};
    localparam sd_cmd_t CMD_PRE = '{1'b0, 1'b0, 1'b1, 1'b0};
    localparam sd_cmd_t CMD_REF = '{1'b0, 1'b0, 1'b0, 1'b1};
    localparam sd_cmd_t CMD_MRS = '{1'b0, 1'b0, 1'b0, 1'b0};

    typedef enum logic [3:0] {
        ST_PWR, ST_IPRE, ST_EMRS, ST_MRS, ST_IREF,
        ST_IDLE, ST_RW, ST_PRE, ST_REF
    } seq_st_t;

    typedef struct packed {
        logic             wr;
        logic             ap;
        logic [BA_W-1:0]  bank;
        logic [COL_W-1:0] col;
    } host_req_t;

    // clock cycles one burst occupies on the data bus
    function automatic logic [2:0] burst_beats(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [ROW_W-1:0] mode_word(input logic cl_half,
                                                   input logic [1:0] code);
        logic [2:0] bl_f;
        logic [2:0] cl_f;
        case (code)
            2'd0:    bl_f = 3'b001;
            2'd1:    bl_f = 3'b010;
            default: bl_f = 3'b011;
        endcase
        cl_f = cl_half ? 3'b110 : 3'b010;
        return {6'b0, cl_f, 1'b0, bl_f};
    endfunction

endpackage

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
    parameter int REFI_CYCLES = 1950
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ack,
    output logic pend
);
    localparam int TW = $clog2(REFI_CYCLES + 1);

    logic [TW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == TW'(REFI_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            cnt  <= wrap ? '0 : cnt + 1'b1;
            pend <= (pend && !ack) || wrap;
        end
    end

    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && pend && !ack) |=> pend);

endmodule

// File: rtl/sdr_rd_window.sv
module sdr_rd_window (
    input  logic       clk,
    input  logic       rst,
    input  logic       fire,
    input  logic       cl_half,
    input  logic [2:0] beats,
    output logic       rd_valid,
    output logic       rd_late
);
    logic       armed;
    logic [1:0] lat;
    logic [2:0] left;
    logic       start;

    assign start = armed && (lat == 2'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            lat      <= '0;
            left     <= '0;
            rd_valid <= 1'b0;
            rd_late  <= 1'b0;
        end else begin
            if (fire) begin
                armed <= 1'b1;
                lat   <= cl_half ? 2'd2 : 2'd1;
            end else if (armed) begin
                if (lat != 2'd0) lat <= lat - 2'd1;
                else             armed <= 1'b0;
            end
            if (start) begin
                rd_valid <= 1'b1;
                rd_late  <= cl_half;
                left     <= beats - 3'd1;
            end else if (rd_valid) begin
                if (left == 3'd0) begin
                    rd_valid <= 1'b0;
                    rd_late  <= 1'b0;
                end else begin
                    left <= left - 3'd1;
                end
            end
        end
    end

    // R8
    late_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        rd_late |-> rd_valid);

    // R8
    window_follows_fire_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> !fire);

endmodule

// File: rtl/sdr_cmd_seq.sv
module sdr_cmd_seq
    import sdr_seq_pkg::*;
#(
    parameter int INIT_CYCLES = 50000,
    parameter int REFI_CYCLES = 1950,
    parameter int TRCD        = 3,
    parameter int TRP         = 3,
    parameter int TRFC        = 19,
    parameter int TMRD        = 2,
    parameter int TWR         = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_cl_half,
    input  logic [1:0]       cfg_bl,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_ap,
    input  logic [BA_W-1:0]  req_bank,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             req_ready,
    output logic             req_done,
    output logic             sd_cke,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [BA_W-1:0]  sd_ba,
    output logic [ROW_W-1:0] sd_addr,
    output logic             rd_valid,
    output logic             rd_late
);
    localparam int CW = $clog2(INIT_CYCLES + REFI_CYCLES + TRFC + 64);

    seq_st_t          st;
    logic [CW-1:0]    gap;
    logic             iref_second;
    host_req_t        cur;
    host_req_t        in_req;
    sd_cmd_t          cmd_q;
    logic [BA_W-1:0]  ba_q;
    logic [ROW_W-1:0] addr_q;
    logic             cke_q;
    logic             done_q;
    logic             ref_pend;
    logic             ref_ack;
    logic             init_done;
    logic             fire_rd;
    logic [2:0]       nbeats;
    logic [CW-1:0]    rw_gap;

    assign in_req    = '{wr: req_write, ap: req_ap, bank: req_bank, col: req_col};
    assign nbeats    = burst_beats(cfg_bl);
    assign init_done = st inside {ST_IDLE, ST_RW, ST_PRE, ST_REF};
    assign req_ready = (st == ST_IDLE) && (gap == '0) && !ref_pend;
    assign ref_ack   = (st == ST_REF) && (gap == '0);
    assign fire_rd   = (st == ST_RW) && (gap == '0) && !cur.wr;

    always_comb begin
        rw_gap = CW'(nbeats) - CW'(1);
        if (cur.wr) rw_gap = rw_gap + CW'(TWR);
        if (cur.ap) rw_gap = rw_gap + CW'(TRP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_PWR;
            gap         <= CW'(INIT_CYCLES - 1);
            iref_second <= 1'b0;
            cur         <= '0;
            cmd_q       <= CMD_NOP;
            ba_q        <= '0;
            addr_q      <= '0;
            cke_q       <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            cmd_q  <= CMD_NOP;
            done_q <= 1'b0;
            if (gap != '0) begin
                gap <= gap - 1'b1;
            end else begin
                case (st)
                    ST_PWR: begin
                        cke_q <= 1'b1;
                        st    <= ST_IPRE;
                    end
                    ST_IPRE: begin
                        cmd_q  <= CMD_PRE;
                        ba_q   <= '0;
                        addr_q <= AP_MASK;
                        gap    <= CW'(TRP - 1);
                        st     <= ST_EMRS;
                    end
                    ST_EMRS: begin
                        cmd_q  <= CMD_MRS;
                        ba_q   <= BA_W'(1);
                        addr_q <= '0;
                        gap    <= CW'(TMRD - 1);
                        st     <= ST_MRS;
                    end
                    ST_MRS: begin
                        cmd_q  <= CMD_MRS;
                        ba_q   <= '0;
                        addr_q <= mode_word(cfg_cl_half, cfg_bl);
                        gap    <= CW'(TMRD - 1);
                        st     <= ST_IREF;
                    end
                    ST_IREF: begin
                        cmd_q       <= CMD_REF;
                        gap         <= CW'(TRFC - 1);
                        iref_second <= 1'b1;
                        if (iref_second) st <= ST_IDLE;
                    end
                    ST_IDLE: begin
                        if (ref_pend) begin
                            cmd_q  <= CMD_PRE;
                            addr_q <= AP_MASK;
                            gap    <= CW'(TRP - 1);
                            st     <= ST_REF;
                        end else if (req_valid) begin
                            cmd_q  <= CMD_ACT;
                            ba_q   <= req_bank;
                            addr_q <= req_row;
                            cur    <= in_req;
                            gap    <= CW'(TRCD - 1);
                            st     <= ST_RW;
                        end
                    end
                    ST_RW: begin
                        cmd_q  <= cur.wr ? CMD_WR : CMD_RD;
                        ba_q   <= cur.bank;
                        addr_q <= ROW_W'(cur.col) | (cur.ap ? AP_MASK : '0);
                        done_q <= 1'b1;
                        gap    <= rw_gap;
                        st     <= cur.ap ? ST_IDLE : ST_PRE;
                    end
                    ST_PRE: begin
                        cmd_q  <= CMD_PRE;
                        ba_q   <= cur.bank;
                        addr_q <= '0;
                        gap    <= CW'(TRP - 1);
                        st     <= ST_IDLE;
                    end
                    ST_REF: begin
                        cmd_q <= CMD_REF;
                        gap   <= CW'(TRFC - 1);
                        st    <= ST_IDLE;
                    end
                    default: st <= ST_PWR;
                endcase
            end
        end
    end

    sdr_ref_timer #(.REFI_CYCLES(REFI_CYCLES)) u_ref_timer (
        .clk  (clk),
        .rst  (rst),
        .en   (init_done),
        .ack  (ref_ack),
        .pend (ref_pend)
    );

    sdr_rd_window u_rd_window (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire_rd),
        .cl_half  (cfg_cl_half),
        .beats    (nbeats),
        .rd_valid (rd_valid),
        .rd_late  (rd_late)
    );

    assign sd_cke   = cke_q;
    assign sd_cs_n  = cmd_q.cs_n;
    assign sd_ras_n = cmd_q.ras_n;
    assign sd_cas_n = cmd_q.cas_n;
    assign sd_we_n  = cmd_q.we_n;
    assign sd_ba    = ba_q;
    assign sd_addr  = addr_q;
    assign req_done = done_q;

    // bus-side age counters used only by the checks below
    logic [3:0] act_age;
    logic [3:0] pre_all_age;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_age     <= '0;
            pre_all_age <= '0;
        end else begin
            if (cmd_q == CMD_ACT)  act_age <= 4'd1;
            else if (act_age != 4'hF) act_age <= act_age + 4'd1;
            if (cmd_q == CMD_PRE && addr_q[AP_POS]) pre_all_age <= 4'd1;
            else if (pre_all_age != 4'hF) pre_all_age <= pre_all_age + 4'd1;
        end
    end

    // R5
    trcd_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> act_age >= 4'(TRCD));

    // R10
    ref_after_pre_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_REF) |-> pre_all_age >= 4'(TRP));

    // R9
    done_with_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        req_done |-> (cmd_q == CMD_RD || cmd_q == CMD_WR));

    // R1
    cke_low_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !sd_cke |-> (!req_ready && cmd_q == CMD_NOP));

endmodule

// File: tb/sdr_cmd_seq_bench.sv
module sdr_cmd_seq_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int INIT_B = 100;
    localparam int REFI_B = 200;
    localparam int TRFC_B = 8;
    localparam int TWR_B  = 2;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cl_half = 1'b0;
    logic [1:0]  bl_code = 2'd1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_ap = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic        req_ready, req_done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic        rd_valid, rd_late;

    always #2ns clk = ~clk;

    sdr_cmd_seq #(
        .INIT_CYCLES(INIT_B), .REFI_CYCLES(REFI_B), .TRFC(TRFC_B)
    ) u_sdr_cmd_seq (
        .clk(clk), .rst(rst), .cfg_cl_half(cl_half), .cfg_bl(bl_code),
        .req_valid(req_valid), .req_write(req_write), .req_ap(req_ap),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_ready(req_ready), .req_done(req_done), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .rd_valid(rd_valid), .rd_late(rd_late)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    typedef struct {
        bit wr;
        bit ap;
        int bank;
        int row;
        int col;
    } exp_t;

    exp_t pend_q[$];
    exp_t cur;

    // command-log reference model
    int  cyc, step, act_cyc[4], act_ok[4], pre_due[4], last_pre_all, last_ref;
    bit  open_b[4];
    bit  ring[64];

    function automatic int beats_of();
        return (bl_code == 2'd0) ? 1 : (bl_code == 2'd1) ? 2 : 4;
    endfunction

    function automatic int mode_exp();
        int bl_f;
        bl_f = (bl_code == 2'd0) ? 1 : (bl_code == 2'd1) ? 2 : 3;
        return ((cl_half ? 6 : 2) << 4) | bl_f;
    endfunction

    always @(negedge clk) begin
        logic [3:0] cm;
        int b, rec, cli;
        bit is_rw, exp_rv;
        if (rst) begin
            cyc = 0; step = 0; last_pre_all = -100; last_ref = 0;
            for (int i = 0; i < 4; i++) begin
                open_b[i] = 1'b0; act_ok[i] = 0; pre_due[i] = -1; act_cyc[i] = 0;
            end
            for (int i = 0; i < 64; i++) ring[i] = 1'b0;
        end else begin
            cyc++;
            cm  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            b   = int'(sd_ba);
            cli = cl_half ? 3 : 2;
            if (cyc < INIT_B)
                chk(sd_cke == 1'b0 && cm == C_NOP, "R1", "cke low and NOP in power-up wait", int'(cm), int'(C_NOP));
            if (step < 5)
                chk(!req_ready, "R2", "ready before init done", int'(req_ready), 0);
            is_rw = (cm == C_RD) || (cm == C_WR);
            chk(req_done == is_rw, "R9", "done coincides with READ/WRITE", int'(req_done), int'(is_rw));
            exp_rv = ring[cyc % 64];
            ring[cyc % 64] = 1'b0;
            chk(rd_valid == exp_rv, "R8", "rd_valid window", int'(rd_valid), int'(exp_rv));
            chk(rd_late == (exp_rv && cl_half), "R8", "rd_late flag", int'(rd_late), int'(exp_rv && cl_half));
            case (cm)
                C_NOP: ;
                C_ACT: begin
                    chk(step == 5, "R2", "ACTIVE before init complete", step, 5);
                    chk(!open_b[b], "R6", "ACTIVE to open bank", int'(open_b[b]), 0);
                    chk(cyc >= act_ok[b], "R7", "ACTIVE after precharge spacing", cyc, act_ok[b]);
                    if (pend_q.size() == 0) begin
                        chk(1'b0, "R9", "ACTIVE without accepted request", 0, 1);
                    end else begin
                        cur = pend_q.pop_front();
                        chk(b == cur.bank, "R4", "ACTIVE bank", b, cur.bank);
                        chk(int'(sd_addr) == cur.row, "R4", "ACTIVE row", int'(sd_addr), cur.row);
                    end
                    open_b[b] = 1'b1;
                    act_cyc[b] = cyc;
                end
                C_RD, C_WR: begin
                    chk(open_b[b] && b == cur.bank, "R4", "READ/WRITE bank", b, cur.bank);
                    chk(cyc - act_cyc[b] == 3, "R5", "ACTIVE to READ/WRITE gap", cyc - act_cyc[b], 3);
                    chk(int'(sd_addr) == ((cur.ap ? 1024 : 0) + cur.col), "R4", "column and AP bit",
                        int'(sd_addr), (cur.ap ? 1024 : 0) + cur.col);
                    chk((cm == C_WR) == cur.wr, "R4", "read/write kind", int'(cm == C_WR), int'(cur.wr));
                    rec = beats_of() + ((cm == C_WR) ? TWR_B : 0);
                    if (cur.ap) begin
                        open_b[b] = 1'b0;
                        act_ok[b] = cyc + rec + 3;
                    end else begin
                        pre_due[b] = cyc + rec;
                    end
                    if (cm == C_RD)
                        for (int i = 0; i < beats_of(); i++) ring[(cyc + cli + i) % 64] = 1'b1;
                end
                C_PRE: begin
                    if (sd_addr[10]) begin
                        if (step == 0) begin
                            chk(cyc >= INIT_B, "R1", "first command time", cyc, INIT_B);
                            chk(sd_cke == 1'b1, "R1", "cke high at first command", int'(sd_cke), 1);
                            step = 1;
                        end
                        for (int i = 0; i < 4; i++) begin
                            chk(!open_b[i], "R10", "bank open at precharge-all", int'(open_b[i]), 0);
                            act_ok[i] = cyc + 3;
                        end
                        last_pre_all = cyc;
                    end else begin
                        chk(open_b[b] && cyc == pre_due[b], "R6", "PRECHARGE time", cyc, pre_due[b]);
                        open_b[b] = 1'b0;
                        act_ok[b] = cyc + 3;
                    end
                end
                C_MRS: begin
                    if (step == 1) begin
                        chk(b == 1 && sd_addr == '0, "R2", "extended mode set", int'(sd_addr), 0);
                        step = 2;
                    end else if (step == 2) begin
                        chk(b == 0, "R2", "base mode set bank", b, 0);
                        chk(int'(sd_addr) == mode_exp(), "R3", "mode word", int'(sd_addr), mode_exp());
                        step = 3;
                    end else begin
                        chk(1'b0, "R2", "MODE SET out of order", step, 1);
                    end
                end
                C_REF: begin
                    chk(step >= 3, "R2", "refresh before mode set", step, 3);
                    chk(cyc - last_pre_all >= 3, "R10", "precharge-all to refresh", cyc - last_pre_all, 3);
                    if (step == 5)
                        chk(cyc - last_ref <= REFI_B + 20, "R10", "refresh spacing", cyc - last_ref, REFI_B + 20);
                    last_ref = cyc;
                    if (step < 5) step++;
                end
                default: chk(1'b0, "R4", "illegal command code", int'(cm), int'(C_NOP));
            endcase
        end
    end

    task automatic host_req(input bit w, input bit ap, input int bank,
                            input int row, input int col);
        exp_t e;
        bit taken;
        e = '{w, ap, bank, row, col};
        taken = 1'b0;
        req_write = w; req_ap = ap;
        req_bank = 2'(bank); req_row = 13'(row); req_col = 10'(col);
        req_valid = 1'b1;
        for (int t = 0; t < 300; t++) begin
            if (req_ready) begin
                pend_q.push_back(e);
                taken = 1'b1;
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(taken, "R9", "request accepted", int'(taken), 1);
    endtask

    task automatic run_phase(input bit clh, input logic [1:0] blc);
        cl_half = clh;
        bl_code = blc;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sd_cke == 1'b0 && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP,
            "R1", "reset bus state", int'(sd_cke), 0);
        chk(!req_ready && !req_done && !rd_valid, "R1", "reset host outputs", int'(req_ready), 0);
        rst = 1'b0;
        for (int t = 0; t < INIT_B + 200 && !req_ready; t++) @(negedge clk);
        chk(req_ready && step == 5, "R2", "ready after init", step, 5);
        host_req(0, 0, 0, 13'h0123, 10'h010);
        host_req(1, 0, 1, 13'h1FFF, 10'h3FF);
        host_req(0, 1, 2, 13'h0AAA, 10'h3FF);
        host_req(1, 1, 3, 13'h1555, 10'h001);
        host_req(0, 0, 2, 13'h0001, 10'h200);
        host_req(0, 1, 2, 13'h0002, 10'h155);
        for (int i = 0; i < 70; i++)
            host_req(i % 2 == 1, i % 3 == 0, i % 4, (i * 613) % 8192, (i * 97) % 1024);
        repeat (2 * REFI_B + 50) @(negedge clk);
        chk(pend_q.size() == 0, "R9", "all requests carried out", pend_q.size(), 0);
        chk(cyc - last_ref <= REFI_B + 20, "R10", "refresh while idle", cyc - last_ref, REFI_B + 20);
    endtask

    initial begin
        @(negedge clk);
        run_phase(1'b0, 2'd1);
        run_phase(1'b1, 2'd2);
        run_phase(1'b1, 2'd0);
        run_phase(1'b0, 2'd2);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule